// File: doc/BRIEF.md
# Saturating Four-Lane Signed Word Adder

This execution unit sits beside a 128-bit vector register file. Each cycle it looks at one 32-bit instruction word. It recognises the signed-word saturating add and pulls out the destination index and the two source indices from the word. The source indices are presented combinationally, so the register file can return both 128-bit operands in the same cycle.

The unit splits each operand into four signed 32-bit lanes and adds matching lanes. A lane whose true sum falls outside the 32-bit signed range is clipped to the nearest limit. One clock later the unit presents the 128-bit result and the destination index, together with a one-cycle valid pulse.

A sticky saturation bit records whether any lane of any accepted add has clipped since software last wrote it. Software can read the bit at any time. Only a dedicated status write port can clear it or load it.

Top module: `vec_sat_word_adder`

## Requirements
- R1: When `instValid` is high and the word has primary opcode 4 in `instWord[31:26]` and extended opcode 896 in `instWord[10:0]`, `resValid` is high for exactly the following cycle. In every other cycle, `resValid` is low. This includes cycles after a non-matching word and cycles after a matching word presented with `instValid` low.
- R2: The source index fields are taken from the instruction word, with bits numbered from the most significant end. `srcAIdx` equals bits 11–15 (`instWord[20:16]`) and `srcBIdx` equals bits 16–20 (`instWord[15:11]`), combinationally. `resDest` equals bits 6–10 (`instWord[25:21]`) of the accepted word and is presented with `resValid`.
- R3: When a lane's true signed sum lies within −2^31 to 2^31−1, the result lane equals that sum exactly.
- R4: A lane whose true sum exceeds 2^31−1 yields 0x7FFFFFFF. A lane whose true sum is below −2^31 yields 0x80000000. For example, 0x7FFFFFFF + 1 gives 0x7FFFFFFF, and 0x80000000 + 0xFFFFFFFF gives 0x80000000.
- R5: Lane 0 occupies bits 127:96, lane 1 bits 95:64, lane 2 bits 63:32 and lane 3 bits 31:0. No carry or borrow crosses a lane boundary.
- R6: The sticky bit `satBit` is set on the same edge that raises `resValid` if any lane of that add clipped.
- R7: Apart from a status write, `satBit` never falls. An accepted add without clipping leaves it unchanged, and a non-matching word leaves it unchanged even if its operands would clip.
- R8: With `statWrEn` high, `satBit` takes `statWrData` at the next edge. If an accepted add clips in the same cycle, that clip is ORed into the written value.
- R9: A synchronous reset (`rst` high at an edge) clears `resValid` and `satBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| srcAIdx | output | 5 | Register index for operand A |
| srcBIdx | output | 5 | Register index for operand B |
| srcA | input | 128 | Operand A vector from the register file |
| srcB | input | 128 | Operand B vector from the register file |
| statWrEn | input | 1 | Status write strobe |
| statWrData | input | 1 | Value to load into the sticky bit |
| resValid | output | 1 | Result pulse, one cycle after acceptance |
| resData | output | 128 | Saturated four-lane sum |
| resDest | output | 5 | Destination register index of the result |
| satBit | output | 1 | Sticky saturation status |

## Verification
The bench pairs every value from a set of edge operands (zero, ±1, both limits, their neighbours and the quarter-range points) in every lane. A wrong clamp direction, a wrap instead of a clip, or an off-by-one limit therefore shows up as a wrong lane value. Lane order errors and any carry leaking across a lane boundary would corrupt the neighbouring word, which the bench detects against its 64-bit reference sum.

The sticky bit is cleared alongside each swept add, so a bit that never sets, or that ignores a clip in one lane, is caught. Directed cases cover a non-matching opcode or extended opcode carrying clipping data, an add that does not clip, and a clear colliding with a clip. A design that decodes loosely, clears the bit on a quiet add, or lets the write override the new event fails these cases.

// File: rtl/satadd_pkg.sv
package satadd_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int OPC_W     = 6;
  localparam int XO_W      = 11;
  localparam logic [OPC_W-1:0] PRIMARY_OPC = 6'd4;
  localparam logic [XO_W-1:0]  EXT_OPC     = 11'd896;

  // strobes from decode to datapath
  typedef struct packed {
    logic                 fire;
    logic [REG_IDX_W-1:0] dest;
  } dpStrobe_t;
endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  output logic [LANE_W-1:0] laneSum,
  output logic              laneClamp
);
  localparam int MSB = LANE_W - 1;
  localparam logic [LANE_W-1:0] POS_LIMIT = {1'b0, {MSB{1'b1}}};
  localparam logic [LANE_W-1:0] NEG_LIMIT = {1'b1, {MSB{1'b0}}};

  logic [LANE_W-1:0] rawSum;
  logic              sameSign;

  always_comb begin
    rawSum    = opA + opB;
    sameSign  = (opA[MSB] == opB[MSB]);
    laneClamp = sameSign && (rawSum[MSB] != opA[MSB]);
    if (laneClamp)
      laneSum = opA[MSB] ? NEG_LIMIT : POS_LIMIT;
    else
      laneSum = rawSum;
  end
endmodule

// File: rtl/sat_add_ctrl.sv
module sat_add_ctrl
  import satadd_pkg::*;
(
  input  logic                 instValid,
  input  logic [INSN_W-1:0]    instWord,
  output logic [REG_IDX_W-1:0] srcAIdx,
  output logic [REG_IDX_W-1:0] srcBIdx,
  output dpStrobe_t            strb
);
  logic [OPC_W-1:0] primField;
  logic [XO_W-1:0]  extField;
  logic             isMatch;

  always_comb begin
    // bit 0 of the word is the most significant bit
    primField = instWord[INSN_W-1 -: OPC_W];
    extField  = instWord[XO_W-1:0];
    srcAIdx   = instWord[INSN_W-1-OPC_W-REG_IDX_W -: REG_IDX_W];
    srcBIdx   = instWord[INSN_W-1-OPC_W-2*REG_IDX_W -: REG_IDX_W];
    isMatch   = (primField == PRIMARY_OPC) && (extField == EXT_OPC);
    strb.fire = instValid && isMatch;
    strb.dest = instWord[INSN_W-1-OPC_W -: REG_IDX_W];
  end
endmodule

// File: rtl/sat_add_dpath.sv
module sat_add_dpath
  import satadd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  dpStrobe_t                 strb,
  input  logic [LANES*LANE_W-1:0]   srcA,
  input  logic [LANES*LANE_W-1:0]   srcB,
  input  logic                      statWrEn,
  input  logic                      statWrData,
  output logic                      resValid,
  output logic [LANES*LANE_W-1:0]   resData,
  output logic [REG_IDX_W-1:0]      resDest,
  output logic                      satBit
);
  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] laneSums;
  logic [LANES-1:0] clampVec;
  logic             anyClamp;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    // lane 0 sits at the top of the vector
    localparam int HI = VEC_W - 1 - g * LANE_W;
    sat_lane #(.LANE_W(LANE_W)) uLane (
      .opA      (srcA[HI -: LANE_W]),
      .opB      (srcB[HI -: LANE_W]),
      .laneSum  (laneSums[HI -: LANE_W]),
      .laneClamp(clampVec[g])
    );

    // two non-negative operands never give a negative lane
    assert_pos_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (strb.fire && !srcA[HI] && !srcB[HI]) |=> !resData[HI]);
    // two negative operands never give a non-negative lane
    assert_neg_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (strb.fire && srcA[HI] && srcB[HI]) |=> resData[HI]);
  end

  assign anyClamp = |clampVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resData  <= '0;
      resDest  <= '0;
      satBit   <= 1'b0;
    end else begin
      resValid <= strb.fire;
      if (strb.fire) begin
        resData <= laneSums;
        resDest <= strb.dest;
      end
      satBit <= (statWrEn ? statWrData : satBit) | (strb.fire & anyClamp);
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    strb.fire |=> resValid);
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!statWrEn && satBit) |=> satBit);
  assert_write_set_R8: assert property (@(posedge clk) disable iff (rst)
    (statWrEn && statWrData) |=> satBit);
  assert_quiet_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (!statWrEn && !strb.fire) |=> $stable(satBit));
endmodule

// File: rtl/vec_sat_word_adder.sv
module vec_sat_word_adder
  import satadd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instValid,
  input  logic [31:0]               instWord,
  output logic [4:0]                srcAIdx,
  output logic [4:0]                srcBIdx,
  input  logic [LANES*LANE_W-1:0]   srcA,
  input  logic [LANES*LANE_W-1:0]   srcB,
  input  logic                      statWrEn,
  input  logic                      statWrData,
  output logic                      resValid,
  output logic [LANES*LANE_W-1:0]   resData,
  output logic [4:0]                resDest,
  output logic                      satBit
);
  dpStrobe_t strb;

  sat_add_ctrl uCtrl (
    .instValid(instValid),
    .instWord (instWord),
    .srcAIdx  (srcAIdx),
    .srcBIdx  (srcBIdx),
    .strb     (strb)
  );

  sat_add_dpath #(.LANES(LANES), .LANE_W(LANE_W)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .srcA      (srcA),
    .srcB      (srcB),
    .statWrEn  (statWrEn),
    .statWrData(statWrData),
    .resValid  (resValid),
    .resData   (resData),
    .resDest   (resDest),
    .satBit    (satBit)
  );

  assert_wrong_primary_R1: assert property (@(posedge clk) disable iff (rst)
    (instWord[31:26] != 6'd4) |=> !resValid);
  assert_wrong_ext_R1: assert property (@(posedge clk) disable iff (rst)
    (instWord[10:0] != 11'd896) |=> !resValid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> !resValid);
endmodule

// File: tb/tb_vec_sat_word_adder.sv
module tb_vec_sat_word_adder;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         instValid;
  logic [31:0]  instWord;
  logic [4:0]   srcAIdx, srcBIdx, resDest;
  logic [127:0] srcA, srcB, resData;
  logic         statWrEn, statWrData, resValid, satBit;

  int compared = 0;
  int mismatched = 0;
  logic expSat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_sat_word_adder dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .srcA(srcA), .srcB(srcB),
    .statWrEn(statWrEn), .statWrData(statWrData), .resValid(resValid),
    .resData(resData), .resDest(resDest), .satBit(satBit)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b,
                                         output logic clip);
    longint sa, sb, s;
    sa = $signed(a);
    sb = $signed(b);
    s  = sa + sb;
    clip = 1'b0;
    if (s > 64'sd2147483647) begin clip = 1'b1; return 32'h7FFF_FFFF; end
    if (s < -64'sd2147483648) begin clip = 1'b1; return 32'h8000_0000; end
    return s[31:0];
  endfunction

  function automatic logic [31:0] mkWord(input logic [5:0] opc, input logic [4:0] d,
                                         input logic [4:0] a, input logic [4:0] b,
                                         input logic [10:0] xo);
    return {opc, d, a, b, xo};
  endfunction

  task automatic runOp(input logic v, input logic [31:0] w,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic we, input logic wd);
    logic match, anyClip, clip;
    logic [127:0] expData;
    @(negedge clk);
    instValid = v; instWord = w; srcA = a; srcB = b;
    statWrEn = we; statWrData = wd;
    #1;
    check("R2", "srcAIdx", {123'd0, srcAIdx}, {123'd0, w[20:16]});
    check("R2", "srcBIdx", {123'd0, srcBIdx}, {123'd0, w[15:11]});
    match = v && (w[31:26] == 6'd4) && (w[10:0] == 11'd896);
    anyClip = 1'b0;
    for (int k = 0; k < 4; k++) begin
      expData[127 - 32*k -: 32] = refAdd(a[127 - 32*k -: 32], b[127 - 32*k -: 32], clip);
      anyClip |= clip;
    end
    expSat = (we ? wd : expSat) | (match & anyClip);
    @(negedge clk);
    instValid = 1'b0; statWrEn = 1'b0;
    check("R1", "resValid", {127'd0, resValid}, {127'd0, match});
    if (match) begin
      check("R2", "resDest", {123'd0, resDest}, {123'd0, w[25:21]});
      check(anyClip ? "R4" : "R3", "resData", resData, expData);
    end
    check(we ? "R8" : (match && anyClip ? "R6" : "R7"), "satBit",
          {127'd0, satBit}, {127'd0, expSat});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] vals [9];
    logic [31:0] addW;
    logic [127:0] va, vb;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h7FFF_FFFE;
    vals[6] = 32'h8000_0001; vals[7] = 32'h4000_0000; vals[8] = 32'hC000_0000;

    rst = 1'b1; instValid = 1'b0; instWord = '0; srcA = '0; srcB = '0;
    statWrEn = 1'b0; statWrData = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9", "resValid after reset", {127'd0, resValid}, 128'd0);
    check("R9", "satBit after reset", {127'd0, satBit}, 128'd0);
    expSat = 1'b0;

    addW = mkWord(6'd4, 5'd3, 5'd7, 5'd19, 11'd896);
    // R4: max + 1 clips high, lane 0; min + -1 clips low, lane 3
    runOp(1'b1, addW, {32'h7FFF_FFFF, 32'd5, 32'd0, 32'h8000_0000},
                      {32'h0000_0001, 32'd6, 32'd0, 32'hFFFF_FFFF}, 1'b0, 1'b0);
    // R7: quiet add keeps the bit
    runOp(1'b1, addW, {4{32'd10}}, {4{32'd20}}, 1'b0, 1'b0);
    // R1/R7: non-matching words carrying clipping data
    runOp(1'b1, mkWord(6'd5, 5'd1, 5'd2, 5'd3, 11'd896),
          {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 1'b1, 1'b0);
    runOp(1'b1, mkWord(6'd4, 5'd1, 5'd2, 5'd3, 11'd897),
          {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 1'b0, 1'b0);
    runOp(1'b1, mkWord(6'd4, 5'd1, 5'd2, 5'd3, 11'd384),
          {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 1'b0, 1'b0);
    runOp(1'b0, addW, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 1'b0, 1'b0);
    // R8: write 1 without an add, then clear colliding with a clip
    runOp(1'b0, 32'd0, '0, '0, 1'b1, 1'b1);
    runOp(1'b1, addW, {32'd0, 32'd0, 32'h8000_0000, 32'd0},
                      {32'd0, 32'd0, 32'h8000_0000, 32'd0}, 1'b1, 1'b0);
    runOp(1'b0, 32'd0, '0, '0, 1'b1, 1'b0);

    // R5: no carry across lanes; lane 1 wraps to zero exactly, lane 0 untouched
    runOp(1'b1, addW, {32'd0, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF},
                      {32'd0, 32'h0000_0001, 32'd0, 32'h0000_0001}, 1'b0, 1'b0);
    check("R5", "lane0 untouched by lane1", {96'd0, resData[127:96]}, 128'd0);
    check("R5", "lane2 untouched by lane3", {96'd0, resData[63:32]}, 128'd0);
    // R5: lane order, distinct values per lane
    runOp(1'b1, addW, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd10, 32'd20, 32'd30, 32'd40},
          1'b0, 1'b0);
    check("R5", "lane0 at top", {96'd0, resData[127:96]}, 128'd11);
    check("R5", "lane3 at bottom", {96'd0, resData[31:0]}, 128'd44);

    // R3/R4/R6: all edge pairs in every lane, sticky cleared alongside each add
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        for (int k = 0; k < 4; k++) begin
          va[127 - 32*k -: 32] = vals[(i + k) % 9];
          vb[127 - 32*k -: 32] = vals[(j + 3*k) % 9];
        end
        runOp(1'b1, mkWord(6'd4, 5'((i*3 + j) % 32), 5'((i + 7*j) % 32),
                           5'((5*i + j + 1) % 32), 11'd896), va, vb, 1'b1, 1'b0);
      end
    end

    // R6/R7: accumulate without clears over mixed patterns
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 4; k++) begin
        va[127 - 32*k -: 32] = 32'(n * 32'h0badf00d + k * 32'h3c3c_1234);
        vb[127 - 32*k -: 32] = 32'(n * 32'h1357_9bdf - k * 32'h0f0f_4321);
      end
      runOp(1'b1, addW, va, vb, 1'b0, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule